// File: doc/BRIEF.md
# Clock-Embedded Synchronous Reset Codec

This block carries a crate-wide synchronous reset on the system clock line itself instead of on a separate wire. The transmit half runs on the controller board. It divides a fast reference clock by a fixed ratio to produce the system clock. On request, it stretches one high phase and shortens the low phase that follows, so the period does not change. The receive half runs on each front-end board in the multiplied clock domain, which is ten times the system clock. It counts how many fast cycles the incoming line stays high and raises a one-cycle strobe once a high phase reaches the reset width.

The strobe loads the fine-timestamp counter with a fixed constant. That constant equals the number of fast edges between the first high sample of the stretched pulse and the load. From then on, the counter reads the number of fast edges since that first high sample. Every board that receives the same pulse therefore passes through zero on the same fast edge. Normal clock pulses may be one cycle wider or narrower than nominal without being taken for a reset.

Both halves share one top so that a loopback of the line exercises the full path. On a board, only one half is used and the other port is tied off.

Top module: `rsync_top`

## Requirements
- R1: While `rstN` is low, `sysClkOut`, `syncStrobe` and `fineTime` are all zero.
- R2: With no request, `sysClkOut` repeats a period of DIV (10) cycles with NORM_HIGH (5) high then 5 low. The first high cycle is the one that follows the first rising edge after `rstN` is released.
- R3: A request sampled at any rising edge inside a period leaves that period's waveform unchanged. The following period is high for 7 cycles and low for 3, and the period after that is normal again.
- R4: Several request cycles within one period produce a single stretched period.
- R5: A high phase on `sysClkIn` that lasts 1 to 6 consecutive samples produces no strobe and does not disturb the fine counter. This range includes the normal width and its one-cycle tolerance either side.
- R6: Once `sysClkIn` has been sampled high on 7 consecutive rising edges, `syncStrobe` is high in the cycle that follows the seventh such edge.
- R7: A high phase of any length, including one much longer than 7, produces at most one strobe.
- R8: `fineTime` (8 bits) increments by one each cycle, modulo 256. On the edge that ends a strobe cycle, it loads 7 instead. It therefore reads k on the k-th edge after the first high sample of the reset pulse.
- R9: When `sysClkOut` is looped into `sysClkIn`, a request makes `fineTime` read 7 exactly eight samples after the stretched pulse first appears on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (reference on the controller, multiplied clock on a front-end board) |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Request to send one stretched reset period |
| sysClkOut | output | 1 | Encoded system clock line produced by the divider |
| sysClkIn | input | 1 | Encoded system clock line as received |
| syncStrobe | output | 1 | One-cycle pulse when a reset-width high phase is recognised |
| fineTime | output | 8 | Fine timestamp counter, realigned by the strobe |

## Verification
The transmit side has one delicate coincidence: a request can arrive on the same edge that closes a period and opens the next one. The bench sweeps the request position over every phase of a period, including the last phase. For each position it checks that the stretched pulse appears in the next period and never in the current one. On the receive side, the counter's reload can fall on the same edge as its ordinary increment. The bench sweeps high-phase widths from 1 to 20 and predicts every counter value arithmetically. Widths of 6 must let the increment through, while widths of 7 and more must replace it with the load.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

  // Commands from the pulse-width decoder to the fine counter.
  typedef struct packed {
    logic load;     // realign: load the alignment constant
    logic advance;  // normal free-running step
  } fineCmd_t;

endpackage

// File: rtl/rsync_encoder.sv
module rsync_encoder #(
  parameter int DIV       = 10,
  parameter int NORM_HIGH = 5,
  parameter int RST_HIGH  = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetReq,
  output logic lineOut
);

  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase, phaseNxt;
  logic          pending, pendingNxt;
  logic          stretch, stretchNxt;
  logic          lineNxt;

  // Look-ahead so the line comes straight from a flop yet tracks the phase.
  always_comb begin
    phaseNxt   = phase + PW'(1);
    stretchNxt = stretch;
    pendingNxt = pending | resetReq;
    if (phase == LAST) begin
      phaseNxt   = '0;
      stretchNxt = pending | resetReq;
      pendingNxt = 1'b0;
    end
    lineNxt = stretchNxt ? (phaseNxt < PW'(RST_HIGH)) : (phaseNxt < PW'(NORM_HIGH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= LAST;
      pending <= 1'b0;
      stretch <= 1'b0;
      lineOut <= 1'b0;
    end else begin
      phase   <= phaseNxt;
      pending <= pendingNxt;
      stretch <= stretchNxt;
      lineOut <= lineNxt;
    end
  end

endmodule

// File: rtl/rsync_ctrl.sv
module rsync_ctrl
  import rsync_pkg::*;
#(
  parameter int RST_MIN = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineIn,
  output fineCmd_t cmd
);

  localparam int CW = $clog2(RST_MIN + 1);

  logic          lineQ;
  logic [CW-1:0] hiCnt;   // completed high samples before this one, saturating

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= 1'b0;
      hiCnt <= '0;
    end else begin
      lineQ <= lineIn;
      if (!lineQ)
        hiCnt <= '0;
      else if (hiCnt != CW'(RST_MIN))
        hiCnt <= hiCnt + CW'(1);
    end
  end

  always_comb begin
    cmd.load    = lineQ && (hiCnt == CW'(RST_MIN - 1));
    cmd.advance = !cmd.load;
  end

endmodule

// File: rtl/rsync_datapath.sv
module rsync_datapath
  import rsync_pkg::*;
#(
  parameter int FINE_W   = 8,
  parameter int LOAD_VAL = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  fineCmd_t          cmd,
  output logic [FINE_W-1:0] fineTime
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      fineTime <= '0;
    else if (cmd.load)
      fineTime <= FINE_W'(LOAD_VAL);
    else if (cmd.advance)
      fineTime <= fineTime + FINE_W'(1);
  end

endmodule

// File: rtl/rsync_top.sv
module rsync_top
  import rsync_pkg::*;
#(
  parameter int DIV       = 10,
  parameter int NORM_HIGH = 5,
  parameter int TOL       = 1,
  parameter int FINE_W    = 8,
  parameter int TRIM      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  output logic              sysClkOut,
  input  logic              sysClkIn,
  output logic              syncStrobe,
  output logic [FINE_W-1:0] fineTime
);

  localparam int RST_HIGH = NORM_HIGH + TOL + 1;
  localparam int RST_MIN  = NORM_HIGH + TOL + 1;
  localparam int LOAD_VAL = RST_MIN + TRIM;

  fineCmd_t cmd;

  rsync_encoder #(.DIV(DIV), .NORM_HIGH(NORM_HIGH), .RST_HIGH(RST_HIGH)) enc_i (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .lineOut(sysClkOut)
  );

  rsync_ctrl #(.RST_MIN(RST_MIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .lineIn(sysClkIn), .cmd(cmd)
  );

  rsync_datapath #(.FINE_W(FINE_W), .LOAD_VAL(LOAD_VAL)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fineTime(fineTime)
  );

  assign syncStrobe = cmd.load;

endmodule

// File: rtl/rsync_checker.sv
module rsync_checker #(
  parameter int DIV       = 10,
  parameter int NORM_HIGH = 5,
  parameter int RST_HIGH  = 7,
  parameter int RST_MIN   = 7,
  parameter int FINE_W    = 8,
  parameter int LOAD_VAL  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysClkOut,
  input logic              sysClkIn,
  input logic              syncStrobe,
  input logic [FINE_W-1:0] fineTime
);

  localparam int GW = $clog2(DIV + 1) + 1;
  localparam int IW = $clog2(RST_MIN + 1) + 1;

  logic          prevOut, seenRise;
  logic [GW-1:0] gapCnt, outRun;
  logic [IW-1:0] inRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut  <= 1'b0;
      seenRise <= 1'b0;
      gapCnt   <= '0;
      outRun   <= '0;
      inRun    <= '0;
    end else begin
      prevOut <= sysClkOut;
      if (sysClkOut && !prevOut) begin
        seenRise <= 1'b1;
        gapCnt   <= GW'(1);
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + GW'(1);
      end
      if (!sysClkOut)        outRun <= '0;
      else if (outRun != '1) outRun <= outRun + GW'(1);
      if (!sysClkIn)         inRun <= '0;
      else if (inRun != '1)  inRun <= inRun + IW'(1);
    end
  end

  assert_enc_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkOut && !prevOut && seenRise) |-> gapCnt == GW'(DIV));

  assert_enc_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sysClkOut && prevOut) |-> (outRun == GW'(NORM_HIGH) || outRun == GW'(RST_HIGH)));

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe == (inRun == IW'(RST_MIN)));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> !syncStrobe);

  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> fineTime == FINE_W'(LOAD_VAL));

  assert_count_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    !syncStrobe |=> fineTime == FINE_W'($past(fineTime) + FINE_W'(1)));

endmodule

bind rsync_top rsync_checker #(
  .DIV(DIV), .NORM_HIGH(NORM_HIGH), .RST_HIGH(RST_HIGH),
  .RST_MIN(RST_MIN), .FINE_W(FINE_W), .LOAD_VAL(LOAD_VAL)
) chk_i (
  .clk(clk), .rstN(rstN), .sysClkOut(sysClkOut), .sysClkIn(sysClkIn),
  .syncStrobe(syncStrobe), .fineTime(fineTime)
);

// File: tb/rsync_top_tb_top.sv
module rsync_top_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, resetReq, loopMode, drvLine;
  logic       sysClkOut, sysClkIn, syncStrobe;
  logic [7:0] fineTime;

  assign sysClkIn = loopMode ? sysClkOut : drvLine;

  rsync_top dut_i (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .sysClkOut(sysClkOut),
    .sysClkIn(sysClkIn), .syncStrobe(syncStrobe), .fineTime(fineTime)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic waitRise();
    logic prevS;
    prevS = sysClkOut;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (sysClkOut && !prevS) return;
      prevS = sysClkOut;
    end
  endtask

  // Request at sample index d for len samples; k = 0 is a rise sample.
  task automatic runEncTrial(input int d, input int len, input string tag);
    int expLine, lastF;
    waitRise();
    lastF = fineTime;
    for (int k = 0; k < 30; k++) begin
      resetReq = (k >= d) && (k < d + len);
      if (k < 10)      expLine = (k < 5);
      else if (k < 20) expLine = (k - 10 < 7);
      else             expLine = (k - 20 < 5);
      chkEq({tag, " line shape"}, sysClkOut, expLine);
      chkEq("R9 strobe position in loopback", syncStrobe, (k == 17));
      if (k >= 18)
        chkEq("R9 aligned fine time", fineTime, k - 11);
      else if (k >= 1)
        chkEq("R8 increment before realign", fineTime, (lastF + 1) % 256);
      lastF = fineTime;
      @(negedge clk);
    end
    resetReq = 1'b0;
  endtask

  task automatic runDecTrial(input int w);
    int f0, expF;
    string tag;
    if (w < 7)       tag = "R5";
    else if (w > 12) tag = "R7";
    else             tag = "R6";
    drvLine = 1'b0;
    repeat (4) @(negedge clk);
    f0 = fineTime;
    drvLine = 1'b1;
    for (int m = 1; m <= w + 3; m++) begin
      @(negedge clk);
      chkEq({tag, " strobe for width sweep"}, syncStrobe, (w >= 7 && m == 7));
      expF = (w >= 7 && m >= 8) ? (m - 1) : ((f0 + m) % 256);
      chkEq("R8 fine time after width sweep pulse", fineTime, expF);
      if (m == w) drvLine = 1'b0;
    end
  endtask

  initial begin
    rstN = 1'b0; resetReq = 1'b0; loopMode = 1'b0; drvLine = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1 sysClkOut in reset", sysClkOut, 0);
    chkEq("R1 syncStrobe in reset", syncStrobe, 0);
    chkEq("R1 fineTime in reset", fineTime, 0);
    rstN = 1'b1;

    // Free-running divider and counter, including counter wrap.
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chkEq("R2 divider waveform", sysClkOut, ((i % 10) < 5));
      chkEq("R8 free count", fineTime, (i + 1) % 256);
      chkEq("R5 no strobe while line idle", syncStrobe, 0);
    end

    // Request position swept over every phase, line looped back.
    loopMode = 1'b1;
    for (int d = 0; d < 10; d++) runEncTrial(d, 1, "R3");
    runEncTrial(3, 4, "R4");
    runEncTrial(8, 2, "R4");

    // Received high-phase width sweep.
    loopMode = 1'b0;
    for (int w = 1; w <= 12; w++) runDecTrial(w);
    runDecTrial(15);
    runDecTrial(20);

    summary();
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

endmodule